// File: doc/BRIEF.md
# Shared Low-Level External Interrupt Controller

This block monitors eight active-low external interrupt pins and folds them into a single interrupt request for the processor. Each pin has its own enable bit. While an enabled pin is held low, a shared sticky request flag is set. The flag drives the one request line, so every pin raises the same interrupt. Software finds the responsible pin by reading the synchronised pin levels. It then acknowledges the request by writing zero to the flag bit.

Pins pass through a two-stage synchroniser before they reach the flag logic. A separate wake output is formed combinationally from the raw pins and the enables, so a low level can bring the processor out of stop mode while no clock is running. A 2-bit priority level is held in a register and presented beside the request. Register access is a plain single-cycle bus: reads are combinational, and writes take effect on the clock edge. There is no streaming data path, so the block has no valid/ready handshake.

Top module: `ext_irq_shared`

## Requirements
- R1: When pin n is low and enable bit n is 1, the flag becomes 1 at the third rising clock edge after the pin level was first sampled low, and not before. This latency comes from two synchroniser stages plus the flag register.
- R2: A low pin whose enable bit is 0 never sets the flag.
- R3: `irq_req` always equals the flag, and the flag is shared by all eight pins.
- R4: Once set, the flag stays 1 when the causing pin returns high or its enable is cleared.
- R5: A write to register 1 with data bit 0 equal to 0 clears the flag. A write with data bit 0 equal to 1 leaves the flag unchanged.
- R6: If a set condition and a clearing write fall in the same cycle, the flag stays 1. A flag cleared while an enabled synchronised pin is still low is 1 again after the next edge.
- R7: `wake` is 1 exactly when some pin n is low at the raw input and enable bit n is 1. No clock edge is needed.
- R8: After reset, the enables are 0x00, the flag is 0, the level is 0, and the synchronised pin view reads 0xFF.
- R9: Read map. Address 0 reads and writes the enables, with bit n enabling pin n. Address 1 reads {5'b0, level[1:0], flag}. Address 2 reads the synchronised pin levels, and writes to it have no effect. Address 3 reads 0.
- R10: A write to address 1 loads level from data bits [2:1], and `irq_level` shows the stored value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_n | input | 8 | Raw external interrupt pins, active low |
| bus_addr | input | 2 | Register select |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data |
| irq_req | output | 1 | Shared interrupt request |
| irq_level | output | 2 | Priority level beside the request |
| wake | output | 1 | Combinational stop-mode wake |

## Verification
Two functions can land in the same cycle: the flag being set by a synchronised low pin, and software clearing the flag with a zero write. The bench holds an enabled pin low and issues the clear write while the set condition is active. It expects the flag to stay high. It then releases the pin and clears again, and expects the flag to fall. A behavioural model tracks the synchroniser delay. It compares the request, level, wake and read data on every clock, under directed and random pin and write traffic.

// File: rtl/extirq_pkg.sv
package extirq_pkg;
  typedef enum logic [1:0] {
    SEL_ENABLE = 2'd0,
    SEL_CTRL   = 2'd1,
    SEL_PINS   = 2'd2,
    SEL_NONE   = 2'd3
  } reg_sel_t;
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] chain [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[s] <= '1;
        else if (s == 0) chain[s] <= d_i;
        else chain[s] <= chain[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/irq_flag_ctl.sv
module irq_flag_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;
    else if (clr_i) flag_o <= 1'b0;
  end

  p_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_o && !clr_i) |=> flag_o);
  p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> flag_o);
  p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !flag_o);
  p_rise_cause_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_o) |-> $past(set_i));
endmodule

// File: rtl/ext_irq_shared.sv
module ext_irq_shared #(
  parameter int NPINS  = 8,
  parameter int LVL_W  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pin_n,
  input  logic [1:0]       bus_addr,
  input  logic             bus_wr,
  input  logic [NPINS-1:0] bus_wdata,
  output logic [NPINS-1:0] bus_rdata,
  output logic             irq_req,
  output logic [LVL_W-1:0] irq_level,
  output logic             wake
);
  import extirq_pkg::*;

  localparam int LVL_LSB = 1;
  localparam int LVL_MSB = LVL_LSB + LVL_W - 1;
  localparam int PAD_W   = NPINS - LVL_W - 1;

  logic [NPINS-1:0] en_q;
  logic [LVL_W-1:0] lvl_q;
  logic [NPINS-1:0] pin_s;
  logic             flag;
  logic             set_cond;
  logic             clr_wr;
  reg_sel_t         sel;

  assign sel = reg_sel_t'(bus_addr);

  pin_sync #(.W(NPINS), .STAGES(STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(pin_n), .q_o(pin_s)
  );

  assign set_cond = |(~pin_s & en_q);
  assign clr_wr   = bus_wr && (sel == SEL_CTRL) && !bus_wdata[0];

  irq_flag_ctl u_flag (
    .clk(clk), .rst_n(rst_n), .set_i(set_cond), .clr_i(clr_wr), .flag_o(flag)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      lvl_q <= '0;
    end else if (bus_wr) begin
      if (sel == SEL_ENABLE) en_q  <= bus_wdata;
      if (sel == SEL_CTRL)   lvl_q <= bus_wdata[LVL_MSB:LVL_LSB];
    end
  end

  always_comb begin
    unique case (sel)
      SEL_ENABLE: bus_rdata = en_q;
      SEL_CTRL:   bus_rdata = {{PAD_W{1'b0}}, lvl_q, flag};
      SEL_PINS:   bus_rdata = pin_s;
      default:    bus_rdata = '0;
    endcase
  end

  assign irq_req   = flag;
  assign irq_level = lvl_q;
  assign wake      = |(~pin_n & en_q);

  p_no_set_disabled_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag && (en_q == '0)) |=> !flag);
  p_level_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && sel == SEL_CTRL) |=> (irq_level == $past(bus_wdata[LVL_MSB:LVL_LSB])));
endmodule

// File: tb/ext_irq_shared_tb.sv
module ext_irq_shared_tb;
  logic       clk = 0;
  logic       rst_n = 0;
  logic [7:0] pin_n = 8'hFF;
  logic [1:0] bus_addr = 0;
  logic       bus_wr = 0;
  logic [7:0] bus_wdata = 0;
  logic [7:0] bus_rdata;
  logic       irq_req;
  logic [1:0] irq_level;
  logic       wake;

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ext_irq_shared u_dut (
    .clk(clk), .rst_n(rst_n), .pin_n(pin_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_req(irq_req),
    .irq_level(irq_level), .wake(wake)
  );

  // behavioural reference
  logic [7:0] m_s1, m_s2, m_en;
  logic [1:0] m_lvl;
  logic       m_flag;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 <= 8'hFF; m_s2 <= 8'hFF; m_en <= 0; m_lvl <= 0; m_flag <= 0;
    end else begin
      bit clr;
      clr = bus_wr && bus_addr == 1 && !bus_wdata[0];
      if ((~m_s2 & m_en) != 0) m_flag <= 1;
      else if (clr) m_flag <= 0;
      m_s2 <= m_s1; m_s1 <= pin_n;
      if (bus_wr && bus_addr == 0) m_en <= bus_wdata;
      if (bus_wr && bus_addr == 1) m_lvl <= bus_wdata[2:1];
    end
  end

  function automatic logic [7:0] m_read();
    case (bus_addr)
      2'd0: return m_en;
      2'd1: return {5'b0, m_lvl, m_flag};
      2'd2: return m_s2;
      default: return 8'h00;
    endcase
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R3", {7'b0, irq_req}, {7'b0, m_flag});
      check("R10", {6'b0, irq_level}, {6'b0, m_lvl});
      check("R7", {7'b0, wake}, {7'b0, |(~pin_n & m_en)});
      check("R9", bus_rdata, m_read());
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk); #1; bus_addr = a; bus_wr = 1; bus_wdata = d;
    @(negedge clk); #1; bus_wr = 0;
  endtask

  task automatic rd(logic [1:0] a);
    @(negedge clk); #1; bus_addr = a;
  endtask

  initial begin
    tick(3); #1 rst_n = 1;
    rd(0); tick(1); check("R8", bus_rdata, 8'h00);
    rd(1); tick(1); check("R8", bus_rdata, 8'h00);
    rd(2); tick(1); check("R8", bus_rdata, 8'hFF);

    // R1: enabled pin 3 low, latency
    wr(0, 8'h08);
    @(negedge clk); #1 pin_n = 8'hF7;
    tick(2); check("R1", {7'b0, irq_req}, 8'h00);
    tick(1); check("R1", {7'b0, irq_req}, 8'h01);
    // R4: release and disable, flag sticks
    #1 pin_n = 8'hFF; wr(0, 8'h00); tick(3);
    check("R4", {7'b0, irq_req}, 8'h01);
    // R5: write 1 no effect, write 0 clears
    wr(1, 8'h01); tick(1); check("R5", {7'b0, irq_req}, 8'h01);
    wr(1, 8'h00); tick(1); check("R5", {7'b0, irq_req}, 8'h00);
    // R2: disabled low pin
    #1 pin_n = 8'hDF; tick(5);
    check("R2", {7'b0, irq_req}, 8'h00);
    check("R7", {7'b0, wake}, 8'h00);
    rd(2); tick(1); check("R9", bus_rdata, 8'hDF);
    wr(2, 8'h00); tick(1); check("R9", bus_rdata, 8'hDF);
    // R7: enabling gives wake at once
    wr(0, 8'hA0); check("R7", {7'b0, wake}, 8'h01);
    tick(2); check("R1", {7'b0, irq_req}, 8'h01);
    // R6: clear while set condition active
    wr(1, 8'h04); tick(1); check("R6", {7'b0, irq_req}, 8'h01);
    check("R10", {6'b0, irq_level}, 8'h02);
    #1 pin_n = 8'hFF; tick(3);
    wr(1, 8'h06); tick(1); check("R5", {7'b0, irq_req}, 8'h00);
    check("R10", {6'b0, irq_level}, 8'h03);
    rd(3); tick(1); check("R9", bus_rdata, 8'h00);

    // random traffic
    for (int i = 0; i < 400; i++) begin
      @(negedge clk); #1;
      if ($urandom_range(0, 3) == 0) pin_n = 8'($urandom);
      else if ($urandom_range(0, 3) == 0) pin_n = 8'hFF;
      bus_addr = 2'($urandom);
      bus_wr = ($urandom_range(0, 4) == 0);
      bus_wdata = 8'($urandom);
    end
    @(negedge clk); #1 bus_wr = 0;
    tick(2);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule